// File: doc/BRIEF.md
# Transmit Abort Condition Monitor

This block watches over a single packet transmission on a 10 Mbit/s half- or full-duplex MAC. A start request from the transmit logic raises the transmit-request output. The monitor then follows the packet through a deferral wait and the transmission itself. While it does so, it counts collisions and bytes sent and times how long the medium stays busy. When one of five fatal conditions occurs, the monitor drops the transmit request and sets a sticky abort flag. In the cycle after that, it issues a one-cycle status-vector write aimed at the word just past the frame's end pointer. The vector carries the cause code, the collision count and the byte count. After an abort there is no retry: the monitor waits in idle until a new start request arrives.

The controller has four states: IDLE, DEFER, XMIT and ABORT. These are its transitions:

- **IDLE → ABORT** ("reject"): a start request for an oversized frame.
- **IDLE → DEFER** ("accept"): any other start request.
- **DEFER → XMIT** ("go"): the medium is idle, or the link is full duplex.
- **DEFER → ABORT** ("defer-out"): the busy-medium timer expires while infinite deferral is off.
- **XMIT → DEFER** ("retry"): an early collision below the collision limit.
- **XMIT → ABORT** ("fatal"): an underrun, a late collision or the sixteenth collision.
- **XMIT → IDLE** ("finish"): the serializer reports the last byte.
- **ABORT → IDLE** ("report"): the status-vector write is made.

In full-duplex mode, carrier sense and collisions are ignored.

Top module: `tx_abort_monitor`

## Requirements
- R1: A start request is taken only in idle. tx_req rises at the first clock edge after it, unless the frame is rejected as oversized. A start that arrives while a packet is in progress is ignored, including its end pointer.
- R2: In half duplex, an early collision while 15 collisions are already counted aborts the packet with cause code 1. The status vector then reports a collision count of 16. Fewer collisions send the packet back to deferral with tx_req still high.
- R3: In half duplex, a collision once 64 or more bytes of the current attempt have been sent aborts with cause code 2. A retry restarts the byte count at zero.
- R4: In half duplex, carrier sense held for DEFER_LIMIT bit ticks during deferral aborts with cause code 3 when cfg_infinite_defer is 0. When it is 1, the packet waits for as long as the medium stays busy.
- R5: A frame_len above max_frame_len aborts at the start with cause code 4 and counts of zero. It is allowed when cfg_huge_en is set, or when both pkt_override and pkt_huge_en are set.
- R6: An underrun during transmission aborts with cause code 5 and sets buf_err_flag, in either duplex mode.
- R7: At the abort edge, tx_req falls and abort_flag rises. In the next cycle, sv_wr_en is high for exactly one cycle with sv_addr equal to frame_end_ptr + 1, modulo 2^ADDR_W.
- R8: In full duplex, carrier sense neither delays nor aborts a packet, and collisions are ignored. Only cause codes 4 and 5 can occur.
- R9: abort_flag and buf_err_flag stay set until clear_abort or clear_buf_err respectively. A new set wins over a clear in the same cycle.
- R10: tx_done during transmission drops tx_req without a status-vector write. After an abort, tx_req stays low until a new start request.
- R11: The status vector reports the collisions counted for the packet and the bytes sent in the current attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Start request pulse for a new packet |
| frame_len | input | LEN_W | Length of the packet in bytes |
| frame_end_ptr | input | ADDR_W | Buffer address of the packet's last byte |
| max_frame_len | input | LEN_W | Programmed maximum frame length |
| cfg_full_duplex | input | 1 | 1 = full duplex |
| cfg_huge_en | input | 1 | Global permission for oversized frames |
| cfg_infinite_defer | input | 1 | 1 = never abort on deferral |
| pkt_override | input | 1 | Per-packet override of the global settings |
| pkt_huge_en | input | 1 | Per-packet oversize permission (needs pkt_override) |
| bit_tick | input | 1 | One pulse per bit time |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision pulse |
| byte_sent | input | 1 | One pulse per byte sent |
| underrun | input | 1 | Buffer could not supply data in time |
| tx_done | input | 1 | Serializer finished the packet |
| clear_abort | input | 1 | Clears abort_flag |
| clear_buf_err | input | 1 | Clears buf_err_flag |
| tx_req | output | 1 | Transmit request bit |
| abort_flag | output | 1 | Sticky abort status |
| buf_err_flag | output | 1 | Sticky buffer-error status |
| sv_wr_en | output | 1 | Status-vector write strobe |
| sv_addr | output | ADDR_W | Status-vector write address |
| sv_cause | output | 3 | Abort cause code (1..5) |
| sv_coll_cnt | output | COLL_W | Collision count |
| sv_byte_cnt | output | LEN_W | Byte count of the current attempt |

## Verification
Every internal fault in this block shows at the ports within a packet, through the status vector or the transmit request.

- **Collision or byte counter:** a miscount changes sv_coll_cnt or sv_byte_cnt in the next write. A wrong comparison point moves the abort by one collision or one byte, which changes the cause code or leaves tx_req high when it should have fallen.
- **Deferral timer or masking:** a fault shows up as a missing or extra write, tens of bit ticks from the expected edge.
- **Controller state:** a wrong state shows within one or two cycles, as tx_req failing to fall, a write strobe wider than one cycle, or a retry after an abort.
- **Flags:** a flag that loses its value shows at the next idle sample.

// File: rtl/tam_pkg.sv
package tam_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_EXCESS    = 3'd1,
        CAUSE_LATE      = 3'd2,
        CAUSE_DEFER     = 3'd3,
        CAUSE_OVERSIZE  = 3'd4,
        CAUSE_UNDERRUN  = 3'd5
    } abort_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEFER = 2'd1,
        ST_XMIT  = 2'd2,
        ST_ABORT = 2'd3
    } tam_state_e;

endpackage

// File: rtl/tam_counters.sv
module tam_counters #(
    parameter int LEN_W    = 16,
    parameter int COLL_MAX = 15,
    parameter int COLL_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_bytes,
    input  logic              inc_byte,
    input  logic              inc_coll,
    output logic [LEN_W-1:0]  byte_cnt,
    output logic [COLL_W-1:0] coll_cnt
);

    localparam logic [LEN_W-1:0] BYTE_SAT = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
        end else if (clr_all || clr_bytes) begin
            byte_cnt <= '0;
        end else if (inc_byte && byte_cnt != BYTE_SAT) begin
            byte_cnt <= byte_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coll_cnt <= '0;
        end else if (clr_all) begin
            coll_cnt <= '0;
        end else if (inc_coll) begin
            coll_cnt <= coll_cnt + 1'b1;
        end
    end

    // R2: the controller stops counting once the limit collision aborts
    a_r2_coll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(coll_cnt) <= COLL_MAX + 1);

endmodule

// File: rtl/tam_defer_timer.sv
module tam_defer_timer #(
    parameter int LIMIT = 24288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);

    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM);

    // R4: the timer saturates and never runs past the limit
    a_r4_timer_sat: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !clr |=> expired);

endmodule

// File: rtl/tam_fsm.sv
module tam_fsm
    import tam_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         oversize,
    input  logic         full_duplex,
    input  logic         infinite_defer,
    input  logic         carrier,
    input  logic         defer_expired,
    input  logic         collision,
    input  logic         late_window,
    input  logic         coll_limit,
    input  logic         underrun,
    input  logic         tx_done,
    output logic         take_start,
    output logic         accept,
    output logic         abort_go,
    output logic         done_go,
    output logic         retry_go,
    output logic         count_coll,
    output logic         in_defer,
    output logic         in_xmit,
    output logic         sv_wr,
    output abort_cause_e cause_d,
    output abort_cause_e cause_q
);

    tam_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state <= state_nx;
            if (abort_go) cause_q <= cause_d;
        end
    end

    // next state and abort cause
    always_comb begin
        state_nx = state;
        cause_d  = CAUSE_NONE;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (oversize) begin
                        state_nx = ST_ABORT;
                        cause_d  = CAUSE_OVERSIZE;
                    end else begin
                        state_nx = ST_DEFER;
                    end
                end
            end
            ST_DEFER: begin
                if (full_duplex || !carrier) begin
                    state_nx = ST_XMIT;
                end else if (defer_expired && !infinite_defer) begin
                    state_nx = ST_ABORT;
                    cause_d  = CAUSE_DEFER;
                end
            end
            ST_XMIT: begin
                if (underrun) begin
                    state_nx = ST_ABORT;
                    cause_d  = CAUSE_UNDERRUN;
                end else if (collision && !full_duplex) begin
                    if (late_window) begin
                        state_nx = ST_ABORT;
                        cause_d  = CAUSE_LATE;
                    end else if (coll_limit) begin
                        state_nx = ST_ABORT;
                        cause_d  = CAUSE_EXCESS;
                    end else begin
                        state_nx = ST_DEFER;
                    end
                end else if (tx_done) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_ABORT: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // decoded outputs
    always_comb begin
        in_defer   = (state == ST_DEFER);
        in_xmit    = (state == ST_XMIT);
        sv_wr      = (state == ST_ABORT);
        take_start = (state == ST_IDLE) && start;
        accept     = take_start && !oversize;
        abort_go   = (state != ST_ABORT) && (state_nx == ST_ABORT);
        done_go    = in_xmit && (state_nx == ST_IDLE);
        retry_go   = in_xmit && (state_nx == ST_DEFER);
        count_coll = in_xmit && collision && !full_duplex && !underrun;
    end

    // R10: an abort is reported once and the controller returns to idle
    a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ABORT |=> state == ST_IDLE);

    // R7: the status-vector strobe lasts a single cycle
    a_r7_wr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sv_wr |=> !sv_wr);

endmodule

// File: rtl/tx_abort_monitor.sv
module tx_abort_monitor
    import tam_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int LEN_W       = 16,
    parameter int COLL_MAX    = 15,
    parameter int LATE_BYTES  = 64,
    parameter int DEFER_LIMIT = 24288,
    parameter int COLL_W      = $clog2(COLL_MAX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [ADDR_W-1:0] frame_end_ptr,
    input  logic [LEN_W-1:0]  max_frame_len,
    input  logic              cfg_full_duplex,
    input  logic              cfg_huge_en,
    input  logic              cfg_infinite_defer,
    input  logic              pkt_override,
    input  logic              pkt_huge_en,
    input  logic              bit_tick,
    input  logic              carrier_sense,
    input  logic              collision,
    input  logic              byte_sent,
    input  logic              underrun,
    input  logic              tx_done,
    input  logic              clear_abort,
    input  logic              clear_buf_err,
    output logic              tx_req,
    output logic              abort_flag,
    output logic              buf_err_flag,
    output logic              sv_wr_en,
    output logic [ADDR_W-1:0] sv_addr,
    output logic [2:0]        sv_cause,
    output logic [COLL_W-1:0] sv_coll_cnt,
    output logic [LEN_W-1:0]  sv_byte_cnt
);

    localparam logic [LEN_W-1:0]  LATE_LIM = LEN_W'(LATE_BYTES);
    localparam logic [COLL_W-1:0] COLL_LIM = COLL_W'(COLL_MAX);

    logic         oversize, huge_ok;
    logic         take_start, accept, abort_go, done_go, retry_go, count_coll;
    logic         in_defer, in_xmit, sv_wr, defer_expired;
    logic [LEN_W-1:0]  byte_cnt;
    logic [COLL_W-1:0] coll_cnt;
    logic [ADDR_W-1:0] addr_q;
    abort_cause_e cause_d, cause_q;

    assign huge_ok  = cfg_huge_en || (pkt_override && pkt_huge_en);
    assign oversize = (frame_len > max_frame_len) && !huge_ok;

    tam_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (tx_start),
        .oversize       (oversize),
        .full_duplex    (cfg_full_duplex),
        .infinite_defer (cfg_infinite_defer),
        .carrier        (carrier_sense),
        .defer_expired  (defer_expired),
        .collision      (collision),
        .late_window    (byte_cnt >= LATE_LIM),
        .coll_limit     (coll_cnt >= COLL_LIM),
        .underrun       (underrun),
        .tx_done        (tx_done),
        .take_start     (take_start),
        .accept         (accept),
        .abort_go       (abort_go),
        .done_go        (done_go),
        .retry_go       (retry_go),
        .count_coll     (count_coll),
        .in_defer       (in_defer),
        .in_xmit        (in_xmit),
        .sv_wr          (sv_wr),
        .cause_d        (cause_d),
        .cause_q        (cause_q)
    );

    tam_counters #(
        .LEN_W    (LEN_W),
        .COLL_MAX (COLL_MAX),
        .COLL_W   (COLL_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (take_start),
        .clr_bytes (retry_go),
        .inc_byte  (in_xmit && byte_sent),
        .inc_coll  (count_coll),
        .byte_cnt  (byte_cnt),
        .coll_cnt  (coll_cnt)
    );

    tam_defer_timer #(
        .LIMIT (DEFER_LIMIT)
    ) u_defer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_defer),
        .run     (in_defer && carrier_sense && bit_tick && !cfg_full_duplex),
        .expired (defer_expired)
    );

    // request bit, sticky flags and vector address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_req       <= 1'b0;
            abort_flag   <= 1'b0;
            buf_err_flag <= 1'b0;
            addr_q       <= '0;
        end else begin
            if (abort_go || done_go) tx_req <= 1'b0;
            else if (accept)         tx_req <= 1'b1;

            if (abort_go)         abort_flag <= 1'b1;
            else if (clear_abort) abort_flag <= 1'b0;

            if (abort_go && cause_d == CAUSE_UNDERRUN) buf_err_flag <= 1'b1;
            else if (clear_buf_err)                   buf_err_flag <= 1'b0;

            if (take_start) addr_q <= frame_end_ptr + 1'b1;
        end
    end

    assign sv_wr_en    = sv_wr;
    assign sv_addr     = addr_q;
    assign sv_cause    = cause_q;
    assign sv_coll_cnt = coll_cnt;
    assign sv_byte_cnt = byte_cnt;

    // R7: request already dropped and flag raised when the vector is written
    a_r7_req_low: assert property (@(posedge clk) disable iff (!rst_n)
        sv_wr_en |-> !tx_req && abort_flag);

    // R8: full duplex only reports oversize or underrun
    a_r8_fd_causes: assert property (@(posedge clk) disable iff (!rst_n)
        sv_wr_en && cfg_full_duplex |-> sv_cause == 3'd4 || sv_cause == 3'd5);

    // R6: an underrun report comes with the buffer-error flag
    a_r6_buf_err: assert property (@(posedge clk) disable iff (!rst_n)
        sv_wr_en && sv_cause == 3'd5 |-> buf_err_flag);

    // R9: the abort flag holds until cleared
    a_r9_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag && !clear_abort |=> abort_flag);

    // R10: no request is raised without a start
    a_r10_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(tx_start));

endmodule

// File: tb/tx_abort_monitor_tb.sv
module tx_abort_monitor_tb;

    localparam int ADDR_W = 13;
    localparam int LEN_W  = 16;
    localparam int COLL_W = 5;
    localparam int DLIM   = 100;

    typedef struct packed {
        logic [2:0]        cause;
        logic [COLL_W-1:0] coll;
        logic [LEN_W-1:0]  bytes;
        logic [ADDR_W-1:0] addr;
    } sv_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_start = 0, cfg_full_duplex = 0, cfg_huge_en = 0, cfg_infinite_defer = 0;
    logic pkt_override = 0, pkt_huge_en = 0, bit_tick = 1, carrier_sense = 0;
    logic collision = 0, byte_sent = 0, underrun = 0, tx_done = 0;
    logic clear_abort = 0, clear_buf_err = 0;
    logic [LEN_W-1:0]  frame_len = 16'd100;
    logic [LEN_W-1:0]  max_frame_len = 16'd1518;
    logic [ADDR_W-1:0] frame_end_ptr = '0;
    logic tx_req, abort_flag, buf_err_flag, sv_wr_en;
    logic [ADDR_W-1:0] sv_addr;
    logic [2:0]        sv_cause;
    logic [COLL_W-1:0] sv_coll_cnt;
    logic [LEN_W-1:0]  sv_byte_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    sv_item_t exp_q[$];

    always #2.5 clk = ~clk;

    tx_abort_monitor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEFER_LIMIT(DLIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .frame_len(frame_len),
        .frame_end_ptr(frame_end_ptr), .max_frame_len(max_frame_len),
        .cfg_full_duplex(cfg_full_duplex), .cfg_huge_en(cfg_huge_en),
        .cfg_infinite_defer(cfg_infinite_defer), .pkt_override(pkt_override),
        .pkt_huge_en(pkt_huge_en), .bit_tick(bit_tick), .carrier_sense(carrier_sense),
        .collision(collision), .byte_sent(byte_sent), .underrun(underrun),
        .tx_done(tx_done), .clear_abort(clear_abort), .clear_buf_err(clear_buf_err),
        .tx_req(tx_req), .abort_flag(abort_flag), .buf_err_flag(buf_err_flag),
        .sv_wr_en(sv_wr_en), .sv_addr(sv_addr), .sv_cause(sv_cause),
        .sv_coll_cnt(sv_coll_cnt), .sv_byte_cnt(sv_byte_cnt)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int cause, input int coll, input int bytes, input logic [ADDR_W-1:0] addr);
        sv_item_t it;
        it.cause = 3'(cause);
        it.coll  = COLL_W'(coll);
        it.bytes = LEN_W'(bytes);
        it.addr  = addr;
        exp_q.push_back(it);
    endtask

    // monitor: every status-vector write is compared with the next expected item
    always @(negedge clk) begin
        if (rst_n && sv_wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected vector write, cause", sv_cause, 0);
            end else begin
                sv_item_t e;
                e = exp_q.pop_front();
                chk(sv_cause == e.cause, "R7/R11 cause", sv_cause, e.cause);
                chk(sv_coll_cnt == e.coll, "R11 collisions", sv_coll_cnt, e.coll);
                chk(sv_byte_cnt == e.bytes, "R11 bytes", sv_byte_cnt, e.bytes);
                chk(sv_addr == e.addr, "R7 address", sv_addr, e.addr);
                chk(!tx_req && abort_flag, "R7 req low and flag set", {tx_req, abort_flag}, 1);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_pkt(input int len, input logic [ADDR_W-1:0] ptr);
        frame_len = LEN_W'(len); frame_end_ptr = ptr; tx_start = 1;
        @(negedge clk); tx_start = 0;
        @(negedge clk);
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            byte_sent = 1; @(negedge clk);
        end
        byte_sent = 0;
    endtask

    task automatic hit_collision();
        collision = 1; @(negedge clk); collision = 0; @(negedge clk);
    endtask

    task automatic finish_pkt();
        tx_done = 1; @(negedge clk); tx_done = 0;
    endtask

    task automatic hit_underrun();
        underrun = 1; @(negedge clk); underrun = 0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        idle(2);
    endtask

    task automatic clear_flags();
        clear_abort = 1; clear_buf_err = 1; @(negedge clk);
        clear_abort = 0; clear_buf_err = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        chk(!tx_req && !abort_flag && !buf_err_flag && !sv_wr_en, "reset state",
            {tx_req, abort_flag, buf_err_flag, sv_wr_en}, 0);
        rst_n = 1;
        idle(2);

        // R1, R10: normal packet
        start_pkt(100, 13'h0100);
        chk(tx_req, "R1 request raised", tx_req, 1);
        send_bytes(100);
        finish_pkt();
        chk(!tx_req && !abort_flag, "R10 done without abort", {tx_req, abort_flag}, 0);
        idle(3);

        // R6, R1: underrun, with a start during transmission that must be ignored
        push(5, 0, 20, 13'h0201);
        start_pkt(100, 13'h0200);
        send_bytes(10);
        start_pkt(100, 13'h0555);
        send_bytes(10);
        hit_underrun();
        drain("R6 underrun report");
        chk(buf_err_flag, "R6 buffer error set", buf_err_flag, 1);
        idle(10);
        chk(abort_flag && buf_err_flag, "R9 flags sticky", {abort_flag, buf_err_flag}, 3);
        chk(!tx_req, "R10 no retry after abort", tx_req, 0);
        clear_flags();
        chk(!abort_flag && !buf_err_flag, "R9 flags cleared", {abort_flag, buf_err_flag}, 0);

        // R2: excess collisions
        push(1, 16, 10, 13'h0301);
        start_pkt(200, 13'h0300);
        for (int c = 0; c < 15; c++) begin
            send_bytes(10);
            hit_collision();
        end
        chk(tx_req && !abort_flag, "R2 fifteen collisions still retried", {tx_req, abort_flag}, 2);
        send_bytes(10);
        hit_collision();
        drain("R2 excess report");
        clear_flags();

        // R3: 63 bytes is early, 64 is late; retry restarts the byte count
        push(2, 2, 64, 13'h0401);
        start_pkt(300, 13'h0400);
        send_bytes(63);
        hit_collision();
        chk(tx_req, "R3 collision at 63 bytes retried", tx_req, 1);
        send_bytes(64);
        hit_collision();
        drain("R3 late report");
        clear_flags();

        // R4: deferral limit
        carrier_sense = 1;
        push(3, 0, 0, 13'h0501);
        start_pkt(100, 13'h0500);
        idle(50);
        chk(tx_req && !abort_flag, "R4 still deferring", {tx_req, abort_flag}, 2);
        drain("R4 defer report");
        clear_flags();

        // R4: infinite deferral never aborts
        cfg_infinite_defer = 1;
        start_pkt(100, 13'h0600);
        idle(3 * DLIM);
        chk(tx_req && !abort_flag, "R4 infinite deferral waits", {tx_req, abort_flag}, 2);
        carrier_sense = 0;
        idle(1);
        send_bytes(5);
        finish_pkt();
        chk(!tx_req, "R4 packet sent after wait", tx_req, 1'b0);
        cfg_infinite_defer = 0;
        idle(2);

        // R5: oversize handling
        push(4, 0, 0, 13'h0701);
        start_pkt(1519, 13'h0700);
        drain("R5 oversize report");
        chk(!tx_req, "R5 oversize never requests", tx_req, 0);
        clear_flags();
        start_pkt(1518, 13'h0710);
        chk(tx_req, "R5 maximum length accepted", tx_req, 1);
        finish_pkt(); idle(2);
        cfg_huge_en = 1;
        start_pkt(2000, 13'h0720);
        chk(tx_req, "R5 global huge enable", tx_req, 1);
        finish_pkt(); idle(2);
        cfg_huge_en = 0; pkt_override = 1;
        push(4, 0, 0, 13'h0731);
        start_pkt(2000, 13'h0730);
        drain("R5 override alone rejects");
        clear_flags();
        pkt_huge_en = 1;
        start_pkt(2000, 13'h0740);
        chk(tx_req && !abort_flag, "R5 per-packet huge enable", {tx_req, abort_flag}, 2);
        finish_pkt(); idle(2);
        pkt_override = 0; pkt_huge_en = 0;

        // R8: full duplex masks carrier and collisions; R7 address wraps
        cfg_full_duplex = 1; carrier_sense = 1;
        start_pkt(100, 13'h0800);
        idle(2 * DLIM);
        for (int c = 0; c < 20; c++) begin
            send_bytes(4);
            hit_collision();
        end
        chk(tx_req && !abort_flag, "R8 full duplex ignores medium", {tx_req, abort_flag}, 2);
        push(5, 0, 3, '0);
        frame_end_ptr = '1;
        finish_pkt(); idle(2);
        start_pkt(100, '1);
        send_bytes(3);
        hit_underrun();
        drain("R8 underrun in full duplex");
        carrier_sense = 0; cfg_full_duplex = 0;

        // R9: set wins over clear in the same cycle
        push(5, 0, 2, 13'h0901);
        start_pkt(100, 13'h0900);
        clear_abort = 1;
        send_bytes(2);
        underrun = 1; @(negedge clk); underrun = 0;
        clear_abort = 0;
        chk(abort_flag, "R9 set wins over clear", abort_flag, 1);
        drain("R9 report");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule